// File: doc/BRIEF.md
# Edge Timestamp Drain to CPU Words

This block sits in a 50 MHz single-edge clock domain and collects pulse records from a fast capture circuit. Each record carries two timestamps (leading and trailing edge), each in carry-save form: a 64-bit sum vector and a 64-bit carry vector. The capture side raises an asynchronous `cap_ready`. The block synchronizes that signal and reads the four vectors. It adds each sum/carry pair in two registered 32-bit halves with a carry between them, queues the two 64-bit binary times, and then acknowledges with `cap_consumed`. The handshake has four phases: ready rises, consumed rises, ready falls, consumed falls.

Resolving the timestamps before the queue halves the storage per record. Each queued record is 128 bits rather than 256. At the queue output a presenter holds the oldest record as four 32-bit words, with a valid flag. A one-cycle `rd_next` strobe from the CPU side retires the word set on display and loads the next record, if there is one.

The intake state machine has five states:
- IDLE waits for the synchronized ready.
- ADD_LO adds the low halves and keeps the carries.
- ADD_HI adds the high halves plus those carries.
- PUSH waits for a free FIFO slot and writes the record.
- ACK drives consumed until the synchronized ready falls.

Its transitions are:
- IDLE→ADD_LO on ready seen.
- ADD_LO→ADD_HI always.
- ADD_HI→PUSH always.
- PUSH→ACK on a push (stays in PUSH while the FIFO is full).
- ACK→IDLE on ready low.

Top module: `stamp_drain`

## Requirements
- R1: After reset, `cap_consumed` and `out_valid` are 0 and all four output words are 0.
- R2: `cap_consumed` rises only in the cycle after the record has been written into the FIFO. `cap_ready` is used only after two synchronizing flops.
- R3: The leading time is (lead_sum + lead_carry) mod 2^64, shown as bits 31:0 on `out_lead_lo` and bits 63:32 on `out_lead_hi`. The trailing time is formed the same way on `out_trail_lo`/`out_trail_hi`.
- R4: A carry out of bit 31 of the low-half sum propagates into the high half. A carry out of bit 63 is discarded.
- R5: Once raised, `cap_consumed` stays high until the synchronized ready is low, and then returns to 0.
- R6: Records reach the output words in the order they were accepted.
- R7: While the FIFO is full, the next record is not acknowledged and is not lost. It is acknowledged after the CPU frees a slot.
- R8: An `rd_next` pulse while `out_valid` is 1 loads the next queued record. If the queue is empty, it clears `out_valid`.
- R9: An `rd_next` pulse while `out_valid` is 0 has no effect: `out_valid` stays 0 and the words are unchanged.
- R10: While `out_valid` is 1 and `rd_next` is 0, the output words do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_ready | input | 1 | Asynchronous record-ready from the capture circuit |
| cap_lead_sum | input | 64 | Leading-edge timestamp, sum vector |
| cap_lead_carry | input | 64 | Leading-edge timestamp, carry vector |
| cap_trail_sum | input | 64 | Trailing-edge timestamp, sum vector |
| cap_trail_carry | input | 64 | Trailing-edge timestamp, carry vector |
| cap_consumed | output | 1 | Record-taken acknowledgement to the capture circuit |
| rd_next | input | 1 | One-cycle CPU strobe: retire the shown record |
| out_valid | output | 1 | Output words hold an unread record |
| out_lead_lo | output | 32 | Leading time bits 31:0 |
| out_lead_hi | output | 32 | Leading time bits 63:32 |
| out_trail_lo | output | 32 | Trailing time bits 31:0 |
| out_trail_hi | output | 32 | Trailing time bits 63:32 |

## Verification
The adder is driven with sum/carry pairs chosen to separate cases:
- An all-zero record.
- A low half that overflows into the high half, which tells a working split-carry path from a dropped one.
- An all-ones plus one pair that must wrap to zero.
- Unrelated mixed patterns, which catch swapped halves or swapped lead/trail words.

Six back-to-back records fill the FIFO and the output register. This shows that order is kept and that the sixth record's acknowledgement is held back, not dropped. Strobes on an empty output check that a spurious `rd_next` is ignored.

// File: rtl/stamp_drain_pkg.sv
package stamp_drain_pkg;
    typedef enum logic [2:0] {
        IN_IDLE,
        IN_ADD_LO,
        IN_ADD_HI,
        IN_PUSH,
        IN_ACK
    } intake_state_t;
endpackage

// File: rtl/stamp_sync2.sv
module stamp_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic meta_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q_sync <= 1'b0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/stamp_intake.sv
module stamp_intake
    import stamp_drain_pkg::*;
#(
    parameter int TS_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rdy_s,
    input  logic [TS_W-1:0]   lead_sum,
    input  logic [TS_W-1:0]   lead_carry,
    input  logic [TS_W-1:0]   trail_sum,
    input  logic [TS_W-1:0]   trail_carry,
    input  logic              full,
    output logic              push,
    output logic [2*TS_W-1:0] rec,
    output logic              consumed
);
    localparam int HALF = TS_W / 2;

    intake_state_t state_q, state_d;
    logic [TS_W-1:0] lead_q, trail_q;
    logic            c_lead_q, c_trail_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IN_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IN_IDLE:   if (rdy_s) state_d = IN_ADD_LO;
            IN_ADD_LO: state_d = IN_ADD_HI;
            IN_ADD_HI: state_d = IN_PUSH;
            IN_PUSH:   if (!full) state_d = IN_ACK;
            IN_ACK:    if (!rdy_s) state_d = IN_IDLE;
            default:   state_d = IN_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        push     = (state_q == IN_PUSH) && !full;
        consumed = (state_q == IN_ACK);
        rec      = {trail_q, lead_q};
    end

    // split carry-save resolution: low halves first, high halves next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_q    <= '0;
            trail_q   <= '0;
            c_lead_q  <= 1'b0;
            c_trail_q <= 1'b0;
        end else if (state_q == IN_ADD_LO) begin
            {c_lead_q, lead_q[HALF-1:0]}   <= {1'b0, lead_sum[HALF-1:0]}  + {1'b0, lead_carry[HALF-1:0]};
            {c_trail_q, trail_q[HALF-1:0]} <= {1'b0, trail_sum[HALF-1:0]} + {1'b0, trail_carry[HALF-1:0]};
        end else if (state_q == IN_ADD_HI) begin
            lead_q[TS_W-1:HALF]  <= lead_sum[TS_W-1:HALF] + lead_carry[TS_W-1:HALF]
                                    + {{(HALF-1){1'b0}}, c_lead_q};
            trail_q[TS_W-1:HALF] <= trail_sum[TS_W-1:HALF] + trail_carry[TS_W-1:HALF]
                                    + {{(HALF-1){1'b0}}, c_trail_q};
        end
    end
endmodule

// File: rtl/stamp_fifo.sv
module stamp_fifo #(
    parameter int W     = 128,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp_q, rp_q;
    logic [AW:0]  fill;

    always_comb begin
        fill  = wp_q - rp_q;
        full  = (fill == (AW+1)'(DEPTH));
        empty = (fill == '0);
        dout  = mem[rp_q[AW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (push && !full) wp_q <= wp_q + 1'b1;
            if (pop && !empty) rp_q <= rp_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[wp_q[AW-1:0]] <= din;
    end
endmodule

// File: rtl/stamp_present.sv
module stamp_present #(
    parameter int TS_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*TS_W-1:0] head,
    input  logic              empty,
    input  logic              rd_next,
    output logic              pop,
    output logic              valid,
    output logic [2*TS_W-1:0] shown
);
    always_comb pop = !empty && (!valid || rd_next);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            shown <= '0;
        end else if (pop) begin
            valid <= 1'b1;
            shown <= head;
        end else if (rd_next) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/stamp_drain.sv
module stamp_drain #(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_ready,
    input  logic [63:0] cap_lead_sum,
    input  logic [63:0] cap_lead_carry,
    input  logic [63:0] cap_trail_sum,
    input  logic [63:0] cap_trail_carry,
    output logic        cap_consumed,
    input  logic        rd_next,
    output logic        out_valid,
    output logic [31:0] out_lead_lo,
    output logic [31:0] out_lead_hi,
    output logic [31:0] out_trail_lo,
    output logic [31:0] out_trail_hi
);
    localparam int TS_W  = 64;
    localparam int REC_W = 2 * TS_W;

    logic             rdy_sync;
    logic             push_en, pop_en, fifo_full, fifo_empty;
    logic [REC_W-1:0] rec_in, rec_head, rec_shown;

    stamp_sync2 u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(cap_ready), .q_sync(rdy_sync)
    );

    stamp_intake #(.TS_W(TS_W)) u_intake (
        .clk(clk), .rst_n(rst_n), .rdy_s(rdy_sync),
        .lead_sum(cap_lead_sum), .lead_carry(cap_lead_carry),
        .trail_sum(cap_trail_sum), .trail_carry(cap_trail_carry),
        .full(fifo_full), .push(push_en), .rec(rec_in), .consumed(cap_consumed)
    );

    stamp_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_en), .din(rec_in),
        .pop(pop_en), .dout(rec_head), .full(fifo_full), .empty(fifo_empty)
    );

    stamp_present #(.TS_W(TS_W)) u_present (
        .clk(clk), .rst_n(rst_n), .head(rec_head), .empty(fifo_empty),
        .rd_next(rd_next), .pop(pop_en), .valid(out_valid), .shown(rec_shown)
    );

    always_comb begin
        out_lead_lo  = rec_shown[31:0];
        out_lead_hi  = rec_shown[63:32];
        out_trail_lo = rec_shown[95:64];
        out_trail_hi = rec_shown[127:96];
    end
endmodule

// File: rtl/stamp_drain_chk.sv
module stamp_drain_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cap_consumed,
    input logic        rdy_s,
    input logic        push,
    input logic        full,
    input logic        empty,
    input logic        out_valid,
    input logic        rd_next,
    input logic [31:0] w0,
    input logic [31:0] w1,
    input logic [31:0] w2,
    input logic [31:0] w3
);
    // R2: acknowledgement only follows a FIFO write
    a_r2_ack_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_consumed) |-> $past(push));

    // R5: consumed held while synchronized ready is high
    a_r5_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_consumed && rdy_s) |=> cap_consumed);

    // R7: no write into a full FIFO
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    // R9: strobe with nothing shown and nothing queued keeps valid low
    a_r9_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && rd_next && empty) |=> !out_valid);

    // R10: shown words hold until the CPU strobes
    a_r10_hold_words: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !rd_next) |=> (out_valid && $stable(w0) && $stable(w1)
                                     && $stable(w2) && $stable(w3)));
endmodule

bind stamp_drain stamp_drain_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cap_consumed(cap_consumed), .rdy_s(rdy_sync),
    .push(push_en), .full(fifo_full), .empty(fifo_empty), .out_valid(out_valid),
    .rd_next(rd_next), .w0(out_lead_lo), .w1(out_lead_hi), .w2(out_trail_lo),
    .w3(out_trail_hi)
);

// File: tb/sim_stamp_drain.sv
`timescale 1ns/1ps
module sim_stamp_drain;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_ready = 1'b0;
    logic [63:0] ls = '0, lc = '0, ts = '0, tc = '0;
    logic        cap_consumed, rd_next = 1'b0, out_valid;
    logic [31:0] w0, w1, w2, w3;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    stamp_drain u0 (
        .clk(clk), .rst_n(rst_n), .cap_ready(cap_ready),
        .cap_lead_sum(ls), .cap_lead_carry(lc), .cap_trail_sum(ts), .cap_trail_carry(tc),
        .cap_consumed(cap_consumed), .rd_next(rd_next), .out_valid(out_valid),
        .out_lead_lo(w0), .out_lead_hi(w1), .out_trail_lo(w2), .out_trail_hi(w3)
    );

    // {lead_sum, lead_carry, trail_sum, trail_carry}
    localparam logic [255:0] VEC [4] = '{
        {64'h0, 64'h0, 64'h0, 64'h0},
        {64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0001,
         64'h1234_0000_8000_0000, 64'h0000_0001_8000_0000},
        {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001,
         64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
        {64'h0123_4567_89AB_CDEF, 64'h1111_2222_3333_4444,
         64'hDEAD_BEEF_0BAD_F00D, 64'h0F0F_0F0F_F0F0_F0F0}
    };

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // four-phase handshake from the capture side
    task automatic send(logic [255:0] v, output bit ok);
        ok = 1'b0;
        @(negedge clk);
        {ls, lc, ts, tc} = v;
        cap_ready = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cap_consumed) begin ok = 1'b1; break; end
        end
        cap_ready = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!cap_consumed) break;
        end
        check("R5 consumed released", {63'd0, cap_consumed}, 64'd0);
    endtask

    task automatic strobe();
        rd_next = 1'b1;
        @(negedge clk);
        rd_next = 1'b0;
    endtask

    task automatic expect_rec(string req, logic [255:0] v);
        logic [63:0] lead, trail;
        lead  = v[255:192] + v[191:128];
        trail = v[127:64] + v[63:0];
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
        check({req, " lead"},  {w1, w0}, lead);
        check({req, " trail"}, {w3, w2}, trail);
    endtask

    function automatic logic [255:0] mk(int k);
        return {64'(k) << 33, 64'(k) * 64'h0101, 64'(k) + 64'hFFFF_FFFF, 64'(k)};
    endfunction

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        bit ok;
        logic [31:0] keep0, keep3;
        tick(3);
        // R1: reset state
        check("R1 consumed", {63'd0, cap_consumed}, 64'd0);
        check("R1 valid", {63'd0, out_valid}, 64'd0);
        check("R1 words", {w3, w2, w1, w0} == '0, 64'd1);
        rst_n = 1'b1;
        tick(2);

        // R3/R4: table walk
        foreach (VEC[i]) begin
            send(VEC[i], ok);
            check("R2 ack seen", {63'd0, ok}, 64'd1);
            tick(1);
            expect_rec("R3 R4 vector", VEC[i]);
            strobe();
            check("R8 empty clears valid", {63'd0, out_valid}, 64'd0);
        end

        // R2: ready must pass two flops; a one-cycle-old ready gives no ack yet
        @(negedge clk);
        {ls, lc, ts, tc} = mk(9);
        cap_ready = 1'b1;
        @(negedge clk);
        check("R2 no early ack", {63'd0, cap_consumed}, 64'd0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cap_consumed) break;
        end
        cap_ready = 1'b0;
        tick(4);
        expect_rec("R2 record", mk(9));
        strobe();

        // R6/R7: fill output register + FIFO (1 + 4)
        for (int k = 1; k <= 5; k++) begin
            send(mk(k), ok);
            check("R6 fill ack", {63'd0, ok}, 64'd1);
        end
        @(negedge clk);
        {ls, lc, ts, tc} = mk(6);
        cap_ready = 1'b1;
        tick(15);
        check("R7 ack withheld when full", {63'd0, cap_consumed}, 64'd0);
        expect_rec("R10 held record", mk(1));
        strobe();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cap_consumed) break;
        end
        check("R7 ack after space", {63'd0, cap_consumed}, 64'd1);
        cap_ready = 1'b0;
        tick(4);
        for (int k = 2; k <= 6; k++) begin
            expect_rec("R6 order", mk(k));
            strobe();
        end
        check("R8 valid low after drain", {63'd0, out_valid}, 64'd0);

        // R9: strobe with nothing shown
        keep0 = w0; keep3 = w3;
        strobe();
        tick(2);
        check("R9 valid stays low", {63'd0, out_valid}, 64'd0);
        check("R9 words unchanged", {keep3, keep0}, {w3, w0});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule